// File: doc/BRIEF.md
# Processor Port Bus Peripheral Hub

This block sits between the port bus of an 8-bit soft processor and the measurement logic of a time interval counter. The processor gives an 8-bit port address, a read strobe, a write strobe and a write data byte. The hub decodes the address and returns a byte from one of several sources. These are the two 16-bit coarse counter captures, each split into a low and a high byte. The others are the fine delay count, the head of the measurement FIFO, the UART receive byte and the UART status byte. Writes become a FIFO push carrying the write byte, or a set of one-cycle control pulses.

Every access takes two cycles. The address is valid in both cycles, and the strobe is high only in the second. The read data leaves through one pipeline register. That register loads the addressed source on every cycle in which the read strobe is low, so it has captured the value by the time the strobe arrives. It then holds that value while the strobe stays high. A read of the FIFO port pops the FIFO once, in the cycle after the strobe.

Top module: `pbus_periph_hub`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_data`, `fifo_pop`, `fifo_push` and `ctrl_pulse` are all zero.
- R2: On each clock edge at which `rd_strobe` is low, `rd_data` loads the source selected by `port_addr`. On each edge at which `rd_strobe` is high, `rd_data` keeps its value even if the sources change.
- R3: The read map is as follows. 0x00 and 0x01 give the low and high bytes of `cnt_ref`, and 0x02 and 0x03 give the low and high bytes of `cnt_loc`. 0x04 gives `fine_cnt` and 0x08 gives `fifo_rdata`. 0x0C gives `uart_data` and 0x0D gives `uart_stat`.
- R4: A read at any other address returns 0x00. This includes the write ports 0x20 and 0x21.
- R5: The first cycle of `rd_strobe` at address 0x08 makes `fifo_pop` high for exactly the next cycle. If the strobe is held high for more cycles, there is still only one pop.
- R6: The first cycle of `wr_strobe` at address 0x20 makes `fifo_push` high for exactly the next cycle, with `fifo_wdata` equal to `wr_data`.
- R7: The first cycle of `wr_strobe` at address 0x21 drives `ctrl_pulse` to `wr_data[3:0]` for exactly the next cycle. At all other times `ctrl_pulse` is zero.
- R8: A strobe of the wrong kind, or at a port without that effect, causes no pop, no push and no control pulse. Examples are a write at 0x08, a read at 0x20 and an access at an unmapped address.
- R9: A write strobe held high for more than one cycle produces only one push or one control pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 8 | Port address, valid for both cycles of an access |
| rd_strobe | input | 1 | Read strobe, high in the second access cycle |
| wr_strobe | input | 1 | Write strobe, high in the second access cycle |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| cnt_ref | input | 16 | Coarse count captured on the reference pulse |
| cnt_loc | input | 16 | Coarse count captured on the local divided edge |
| fine_cnt | input | 8 | Fine delay line count |
| fifo_rdata | input | 8 | Head of the measurement FIFO |
| uart_data | input | 8 | UART received byte |
| uart_stat | input | 8 | UART status byte |
| fifo_pop | output | 1 | One-cycle FIFO read advance |
| fifo_push | output | 1 | One-cycle FIFO write |
| fifo_wdata | output | 8 | Byte written to the FIFO |
| ctrl_pulse | output | 4 | One-cycle control pulses |

## Verification
The embedded assertions check the following on every cycle:
- `rd_data` is held while the read strobe is high.
- Every pop, push and control pulse lasts one cycle and follows a strobe of the right kind at the right port.
- An unmapped address loads zero.

The correct byte from each mapped source, the split of the counts into low and high bytes, the write data carried with a push, and the absence of effects for strobes of the wrong kind can only be shown by the bench. It compares these results against its own address map. It uses random accesses and directed cases, including strobes held high.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned PB_AW  = 8;
  localparam int unsigned PB_DW  = 8;
  localparam int unsigned CNT_W  = 2 * PB_DW;
  localparam int unsigned CTRL_W = 4;

  typedef logic [PB_AW-1:0] pb_addr_t;
  typedef logic [PB_DW-1:0] pb_data_t;

  localparam pb_addr_t RD_REF_LO = 8'h00;
  localparam pb_addr_t RD_REF_HI = 8'h01;
  localparam pb_addr_t RD_LOC_LO = 8'h02;
  localparam pb_addr_t RD_LOC_HI = 8'h03;
  localparam pb_addr_t RD_FINE   = 8'h04;
  localparam pb_addr_t RD_FIFO   = 8'h08;
  localparam pb_addr_t RD_UDAT   = 8'h0C;
  localparam pb_addr_t RD_USTAT  = 8'h0D;
  localparam pb_addr_t WR_FIFO   = 8'h20;
  localparam pb_addr_t WR_CTRL   = 8'h21;

  function automatic logic rd_mapped(pb_addr_t a);
    return (a == RD_REF_LO) || (a == RD_REF_HI) || (a == RD_LOC_LO) ||
           (a == RD_LOC_HI) || (a == RD_FINE)   || (a == RD_FIFO)   ||
           (a == RD_UDAT)   || (a == RD_USTAT);
  endfunction
endpackage

// File: rtl/pbus_strobe_edge.sv
module pbus_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic first
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign first = strobe & ~strobe_q;
endmodule

// File: rtl/pbus_read_path.sv
module pbus_read_path
  import pbus_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pb_addr_t           addr,
  input  logic               rd_strobe,
  input  logic               rd_first,
  input  logic [CNT_W-1:0]   cnt_ref,
  input  logic [CNT_W-1:0]   cnt_loc,
  input  pb_data_t           fine_cnt,
  input  pb_data_t           fifo_rdata,
  input  pb_data_t           uart_data,
  input  pb_data_t           uart_stat,
  output pb_data_t           rd_data,
  output logic               fifo_pop
);
  localparam int unsigned NBYTES = CNT_W / PB_DW;

  pb_data_t ref_b [NBYTES];
  pb_data_t loc_b [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_split
    assign ref_b[i] = cnt_ref[i*PB_DW +: PB_DW];
    assign loc_b[i] = cnt_loc[i*PB_DW +: PB_DW];
  end

  pb_data_t sel_d;
  always_comb begin
    case (addr)
      RD_REF_LO: sel_d = ref_b[0];
      RD_REF_HI: sel_d = ref_b[1];
      RD_LOC_LO: sel_d = loc_b[0];
      RD_LOC_HI: sel_d = loc_b[1];
      RD_FINE:   sel_d = fine_cnt;
      RD_FIFO:   sel_d = fifo_rdata;
      RD_UDAT:   sel_d = uart_data;
      RD_USTAT:  sel_d = uart_stat;
      default:   sel_d = '0;
    endcase
  end

  pb_data_t rd_q;
  logic     pop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      pop_q <= 1'b0;
    end else begin
      if (!rd_strobe) rd_q <= sel_d;
      pop_q <= rd_first && (addr == RD_FIFO);
    end
  end

  assign rd_data  = rd_q;
  assign fifo_pop = pop_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> $stable(rd_data)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rd_strobe && !rd_mapped(addr)) |=> (rd_data == '0)); // R4
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop); // R5
  AST_POP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> ($past(rd_strobe) && ($past(addr) == RD_FIFO))); // R5
endmodule

// File: rtl/pbus_write_decode.sv
module pbus_write_decode
  import pbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  pb_addr_t          addr,
  input  logic              wr_strobe,
  input  logic              wr_first,
  input  pb_data_t          wr_data,
  output logic              fifo_push,
  output pb_data_t          fifo_wdata,
  output logic [CTRL_W-1:0] ctrl_pulse
);
  logic              push_q;
  pb_data_t          wdata_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      push_q  <= 1'b0;
      wdata_q <= '0;
      ctrl_q  <= '0;
    end else begin
      push_q <= wr_first && (addr == WR_FIFO);
      if (wr_first && (addr == WR_FIFO)) wdata_q <= wr_data;
      ctrl_q <= (wr_first && (addr == WR_CTRL)) ? wr_data[CTRL_W-1:0] : '0;
    end
  end

  assign fifo_push  = push_q;
  assign fifo_wdata = wdata_q;
  assign ctrl_pulse = ctrl_q;

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push); // R9
  AST_PUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> ($past(wr_strobe) && ($past(addr) == WR_FIFO))); // R6
  AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_strobe) |-> (ctrl_pulse == '0)); // R7
  AST_CTRL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_pulse != '0) |=> (ctrl_pulse == '0)); // R9
endmodule

// File: rtl/pbus_periph_hub.sv
module pbus_periph_hub
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  port_addr,
  input  logic        rd_strobe,
  input  logic        wr_strobe,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic [15:0] cnt_ref,
  input  logic [15:0] cnt_loc,
  input  logic [7:0]  fine_cnt,
  input  logic [7:0]  fifo_rdata,
  input  logic [7:0]  uart_data,
  input  logic [7:0]  uart_stat,
  output logic        fifo_pop,
  output logic        fifo_push,
  output logic [7:0]  fifo_wdata,
  output logic [3:0]  ctrl_pulse
);
  logic rd_first, wr_first;

  pbus_strobe_edge u_rd_edge (
    .clk(clk), .rst(rst), .strobe(rd_strobe), .first(rd_first)
  );

  pbus_strobe_edge u_wr_edge (
    .clk(clk), .rst(rst), .strobe(wr_strobe), .first(wr_first)
  );

  pbus_read_path u_read (
    .clk(clk), .rst(rst), .addr(port_addr), .rd_strobe(rd_strobe),
    .rd_first(rd_first), .cnt_ref(cnt_ref), .cnt_loc(cnt_loc),
    .fine_cnt(fine_cnt), .fifo_rdata(fifo_rdata), .uart_data(uart_data),
    .uart_stat(uart_stat), .rd_data(rd_data), .fifo_pop(fifo_pop)
  );

  pbus_write_decode u_write (
    .clk(clk), .rst(rst), .addr(port_addr), .wr_strobe(wr_strobe),
    .wr_first(wr_first), .wr_data(wr_data), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .ctrl_pulse(ctrl_pulse)
  );

  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && fifo_push)); // R8
endmodule

// File: tb/pbus_periph_hub_tb_top.sv
module pbus_periph_hub_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic [7:0]  port_addr;
  logic        rd_strobe, wr_strobe;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [15:0] cnt_ref, cnt_loc;
  logic [7:0]  fine_cnt, fifo_rdata, uart_data, uart_stat;
  logic        fifo_pop, fifo_push;
  logic [7:0]  fifo_wdata;
  logic [3:0]  ctrl_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pbus_periph_hub dut_i (
    .clk(clk), .rst(rst), .port_addr(port_addr), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_data(rd_data),
    .cnt_ref(cnt_ref), .cnt_loc(cnt_loc), .fine_cnt(fine_cnt),
    .fifo_rdata(fifo_rdata), .uart_data(uart_data), .uart_stat(uart_stat),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .ctrl_pulse(ctrl_pulse)
  );

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return cnt_ref[7:0];
      8'h01: return cnt_ref[15:8];
      8'h02: return cnt_loc[7:0];
      8'h03: return cnt_loc[15:8];
      8'h04: return fine_cnt;
      8'h08: return fifo_rdata;
      8'h0C: return uart_data;
      8'h0D: return uart_stat;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_mapped(logic [7:0] a);
    return a inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h0C, 8'h0D};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shuffle_sources();
    cnt_ref    = 16'($urandom);
    cnt_loc    = 16'($urandom);
    fine_cnt   = 8'($urandom);
    fifo_rdata = 8'($urandom);
    uart_data  = 8'($urandom);
    uart_stat  = 8'($urandom);
  endtask

  task automatic access(bit is_wr, logic [7:0] a, logic [7:0] d, bit hold);
    logic [7:0] rd_seen;
    bit exp_pop, exp_push;
    logic [3:0] exp_ctrl;
    exp_pop  = !is_wr && (a == 8'h08);
    exp_push = is_wr && (a == 8'h20);
    exp_ctrl = (is_wr && (a == 8'h21)) ? d[3:0] : 4'h0;
    @(negedge clk);
    port_addr = a; wr_data = d; rd_strobe = 0; wr_strobe = 0;
    shuffle_sources();
    @(negedge clk);
    if (is_wr) wr_strobe = 1; else rd_strobe = 1;
    #1;
    rd_seen = rd_data;
    if (!is_wr) begin
      if (is_mapped(a)) chk("R3 read byte", rd_data, exp_read(a));
      else              chk("R4 unmapped read", rd_data, 8'h00);
    end
    chk("R5 no early pop", fifo_pop, 0);
    chk("R6 no early push", fifo_push, 0);
    @(negedge clk);
    if (hold) shuffle_sources();
    else begin rd_strobe = 0; wr_strobe = 0; end
    #1;
    chk(exp_pop ? "R5 pop" : "R8 no pop", fifo_pop, exp_pop);
    chk(exp_push ? "R6 push" : "R8 no push", fifo_push, exp_push);
    if (exp_push) chk("R6 push data", fifo_wdata, d);
    chk(exp_ctrl != 0 ? "R7 ctrl pulse" : "R8 ctrl idle", ctrl_pulse, exp_ctrl);
    if (hold && !is_wr) chk("R2 hold while strobe", rd_data, rd_seen);
    @(negedge clk);
    rd_strobe = 0; wr_strobe = 0;
    #1;
    chk("R5 pop one cycle", fifo_pop, 0);
    chk("R9 push one cycle", fifo_push, 0);
    chk("R9 ctrl one cycle", ctrl_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] mapped_list [10];
    mapped_list = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h0C, 8'h0D, 8'h20, 8'h21};
    void'($urandom(32'd20240611));
    rst = 1; port_addr = 8'h08; rd_strobe = 1; wr_strobe = 1; wr_data = 8'hFF;
    cnt_ref = 16'hA5A5; cnt_loc = 16'h5A5A; fine_cnt = 8'h11;
    fifo_rdata = 8'h22; uart_data = 8'h33; uart_stat = 8'h44;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset pop", fifo_pop, 0);
    chk("R1 reset push", fifo_push, 0);
    chk("R1 reset ctrl", ctrl_pulse, 0);
    @(negedge clk);
    rst = 0; rd_strobe = 0; wr_strobe = 0; port_addr = 8'hFF;
    #1;
    chk("R1 first cycle rd_data", rd_data, 0);
    chk("R1 first cycle pop", fifo_pop, 0);

    for (int i = 0; i < 8; i++) access(0, mapped_list[i], 8'h00, 0);
    access(0, 8'hFF, 8'h00, 0);
    access(0, 8'h21, 8'h00, 0);
    access(0, 8'h20, 8'h00, 0);
    access(1, 8'h08, 8'h5C, 0);
    access(1, 8'h20, 8'hC3, 0);
    access(1, 8'h21, 8'h0F, 0);
    access(1, 8'h77, 8'hFF, 0);
    access(0, 8'h08, 8'h00, 1);
    access(0, 8'h01, 8'h00, 1);
    access(1, 8'h20, 8'h96, 1);
    access(1, 8'h21, 8'h0A, 1);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int r;
      r = int'($urandom % 14);
      a = (r < 10) ? mapped_list[r] : 8'($urandom);
      access(1'($urandom), a, 8'($urandom), (($urandom % 4) == 0));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule